// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Programmable Watermarks

This block is a first-in first-out buffer of 18-bit words. It has a write port and a read port, and each port runs on its own clock. The two clocks may be driven from one source or run independently. On each write-clock edge where the write strobe is high, one word is stored. On each read-clock edge where the read strobe is high, the oldest unread word moves into the output register. Both ports may be active on the same edge. Each pointer is converted to Gray code and passed through a two-flop synchronizer into the other clock domain.

Five flags report how full the buffer is. Empty and almost-empty are driven from the read domain. Full, half-full and almost-full are driven from the write domain. The two watermark thresholds live in registers. Software loads them through the data input while the `load` strobe is high, and reads them back through the data output the same way. A small two-state sequencer on each side picks which threshold the next access goes to. In the state `SEL_LOW_MARK` the access goes to the almost-empty threshold. In the state `SEL_HIGH_MARK` it goes to the almost-full threshold. Every programming or readback access moves the sequencer on its own side to the other state: `SEL_LOW_MARK` to `SEL_HIGH_MARK`, and `SEL_HIGH_MARK` back to `SEL_LOW_MARK`. A rewind input sends the read position back to the first word stored since reset, so that the data can be sent again. A mode input decides whether the two watermark flags come from a register or straight from the occupancy compare.

Top module: `pflag_fifo`

## Requirements
- R1: Words come out of `rd_data` in the order they were written. The output register loads on the read-clock edge that accepts a read and holds its value between reads.
- R2: `full` is high when the write-side occupancy (write pointer minus the synchronized read pointer) equals DEPTH. A write strobe while `full` is high stores nothing.
- R3: `empty` is high when the read-side occupancy (synchronized write pointer minus read pointer) is zero. A read strobe while `empty` is high leaves the read position and `rd_data` unchanged.
- R4: `half_full` is high when the write-side occupancy is greater than DEPTH/2.
- R5: `almost_full` is high when the write-side occupancy is at least DEPTH minus the high mark. `almost_empty` is high when the read-side occupancy is at most the low mark.
- R6: When `sync_mode` is 1, `almost_full` and `almost_empty` show the value of the compare one clock later, through a register. When `sync_mode` is 0, they follow the compare directly.
- R7: An edge with `load` and `wr_en` both high writes bits [log2(DEPTH)-1:0] of `wr_data` into a threshold register and stores no FIFO word. The writes go to the low mark first and the high mark second, then alternate.
- R8: An edge with `load` and `rd_en` both high places a threshold, zero-extended, into `rd_data` and reads no FIFO word. The low mark comes first and the high mark second, then they alternate.
- R9: With `retx` high on a read edge, the read position returns to the first word written since reset, and that edge reads no word.
- R10: Reset forces `empty` and `almost_empty` high; `full`, `half_full` and `almost_full` low; both thresholds to 7; both sequencers to `SEL_LOW_MARK`; and `rd_data` to 0.
- R11: While `out_en` is low, `rd_data` is 0. `out_en` has no effect on reads or on the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word or threshold value to store |
| load | input | 1 | Steers strobes to the threshold registers |
| rd_en | input | 1 | Read strobe |
| retx | input | 1 | Rewind the read position to the first word |
| out_en | input | 1 | Output enable; low forces `rd_data` to 0 |
| sync_mode | input | 1 | 1 = registered watermark flags |
| rd_data | output | DW | Output word register, gated by `out_en` |
| empty | output | 1 | No unread words (read domain) |
| almost_empty | output | 1 | Occupancy at or below the low mark |
| half_full | output | 1 | Occupancy above half |
| almost_full | output | 1 | Occupancy at or above DEPTH minus the high mark |
| full | output | 1 | Occupancy equals DEPTH (write domain) |

## Verification
The assertions assume `sync_mode` changes only between traffic phases. They also assume that `retx` is raised only after no more than DEPTH words have been written since reset, so the rewound position still holds valid data. Finally, they assume the thresholds are not reprogrammed while a watermark compare is being checked. The stimulus ties both clocks together, so synchronizer latency is a fixed two cycles and the reference model can predict every flag cycle by cycle. It toggles `sync_mode` only between full fill-and-drain passes, and it resets the block before the rewind sequence so that fewer than DEPTH writes come before the `retx` pulse.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
    // Selects which threshold the next load-strobe access reaches.
    typedef enum logic {
        SEL_LOW_MARK  = 1'b0,
        SEL_HIGH_MARK = 1'b1
    } mark_sel_e;

    localparam int MARK_RESET = 7;
endpackage

// File: rtl/pflag_fifo_gray_sync.sv
module pflag_fifo_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pflag_fifo_mem.sv
module pflag_fifo_mem #(
    parameter int DW = 18,
    parameter int AW = 12
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pflag_fifo_wr_side.sv
module pflag_fifo_wr_side
    import pflag_fifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 12
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          load,
    input  logic          sync_mode,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] low_mark,
    output logic [AW-1:0] high_mark,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);
    localparam logic [AW:0]   CAP      = (AW+1)'(1) << AW;
    localparam logic [AW:0]   HALF     = CAP >> 1;
    localparam logic [AW-1:0] MARK_RST = AW'(MARK_RESET);

    logic [AW:0] rptr_s;
    logic [AW:0] used;
    logic [AW:0] wptr_nxt;
    logic        af_c, af_q, prog_we;
    mark_sel_e   sel_q, sel_d;

    // Gray to binary for the synchronized read pointer.
    always_comb begin
        for (int i = 0; i <= AW; i++) rptr_s[i] = ^(rgray_s >> i);
    end

    assign used        = wptr - rptr_s;
    assign full        = (used == CAP);
    assign half_full   = (used > HALF);
    assign af_c        = (used >= (CAP - {1'b0, high_mark}));
    assign almost_full = sync_mode ? af_q : af_c;

    assign prog_we   = wr_en & load;
    assign mem_we    = wr_en & ~load & ~full;
    assign mem_waddr = wptr[AW-1:0];
    assign wptr_nxt  = wptr + (AW+1)'(mem_we);

    // Threshold sequencer: state register.
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_LOW_MARK;
        else        sel_q <= sel_d;
    end

    // Threshold sequencer: next state.
    always_comb begin
        sel_d = sel_q;
        unique case (sel_q)
            SEL_LOW_MARK:  if (prog_we) sel_d = SEL_HIGH_MARK;
            SEL_HIGH_MARK: if (prog_we) sel_d = SEL_LOW_MARK;
        endcase
    end

    // Threshold sequencer: outputs (register loads).
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            low_mark  <= MARK_RST;
            high_mark <= MARK_RST;
        end else if (prog_we) begin
            unique case (sel_q)
                SEL_LOW_MARK:  low_mark  <= din[AW-1:0];
                SEL_HIGH_MARK: high_mark <= din[AW-1:0];
            endcase
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
            af_q  <= 1'b0;
        end else begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
            af_q  <= af_c;
        end
    end
endmodule

// File: rtl/pflag_fifo_rd_side.sv
module pflag_fifo_rd_side
    import pflag_fifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 12
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          load,
    input  logic          retx,
    input  logic          sync_mode,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] low_mark,
    input  logic [AW-1:0] high_mark,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] mem_raddr,
    output logic [DW-1:0] word_q,
    output logic          empty,
    output logic          almost_empty
);
    logic [AW:0] wptr_s;
    logic [AW:0] avail;
    logic [AW:0] rptr_nxt;
    logic        ae_c, ae_q, rd_fire, peek;
    mark_sel_e   sel_q, sel_d;

    // Gray to binary for the synchronized write pointer.
    always_comb begin
        for (int i = 0; i <= AW; i++) wptr_s[i] = ^(wgray_s >> i);
    end

    assign avail        = wptr_s - rptr;
    assign empty        = (avail == '0);
    assign ae_c         = (avail <= {1'b0, low_mark});
    assign almost_empty = sync_mode ? ae_q : ae_c;

    assign rd_fire   = rd_en & ~load & ~empty & ~retx;
    assign peek      = rd_en & load;
    assign mem_raddr = rptr[AW-1:0];
    assign rptr_nxt  = retx ? '0 : rptr + (AW+1)'(rd_fire);

    // Readback sequencer: state register.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_LOW_MARK;
        else        sel_q <= sel_d;
    end

    // Readback sequencer: next state.
    always_comb begin
        sel_d = sel_q;
        unique case (sel_q)
            SEL_LOW_MARK:  if (peek) sel_d = SEL_HIGH_MARK;
            SEL_HIGH_MARK: if (peek) sel_d = SEL_LOW_MARK;
        endcase
    end

    // Output word register: FIFO data or threshold readback.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (rd_fire) begin
            word_q <= mem_rdata;
        end else if (peek) begin
            unique case (sel_q)
                SEL_LOW_MARK:  word_q <= DW'(low_mark);
                SEL_HIGH_MARK: word_q <= DW'(high_mark);
            endcase
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
            ae_q  <= 1'b1;
        end else begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
            ae_q  <= ae_c;
        end
    end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
    parameter int DW    = 18,
    parameter int DEPTH = 4096
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    input  logic          rd_en,
    input  logic          retx,
    input  logic          out_en,
    input  logic          sync_mode,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          half_full,
    output logic          almost_full,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]   wr_ptr, rd_ptr, wgray, rgray, wgray_s, rgray_s;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr, low_mark, high_mark;
    logic [DW-1:0] mem_rdata, rd_word;

    pflag_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    pflag_fifo_gray_sync #(.W(AW+1)) u_rsync (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    pflag_fifo_gray_sync #(.W(AW+1)) u_wsync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    pflag_fifo_wr_side #(.DW(DW), .AW(AW)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .load        (load),
        .sync_mode   (sync_mode),
        .din         (wr_data),
        .rgray_s     (rgray_s),
        .wptr        (wr_ptr),
        .wgray       (wgray),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .low_mark    (low_mark),
        .high_mark   (high_mark),
        .full        (full),
        .half_full   (half_full),
        .almost_full (almost_full)
    );

    pflag_fifo_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .load         (load),
        .retx         (retx),
        .sync_mode    (sync_mode),
        .wgray_s      (wgray_s),
        .mem_rdata    (mem_rdata),
        .low_mark     (low_mark),
        .high_mark    (high_mark),
        .rptr         (rd_ptr),
        .rgray        (rgray),
        .mem_raddr    (mem_raddr),
        .word_q       (rd_word),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    assign rd_data = out_en ? rd_word : '0;
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
    parameter int PW = 13,
    parameter int DW = 18
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          load,
    input logic          retx,
    input logic          sync_mode,
    input logic          full,
    input logic          empty,
    input logic          half_full,
    input logic          almost_full,
    input logic          almost_empty,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [DW-1:0] rd_word
);
    p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en && !load) |=> $stable(wr_ptr));

    p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en && !load && !retx) |=> ($stable(rd_ptr) && $stable(rd_word)));

    p_full_half_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> half_full);

    p_full_af_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && !sync_mode) |-> almost_full);

    p_empty_ae_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && !sync_mode) |-> almost_empty);

    p_mark_write_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && load) |=> $stable(wr_ptr));

    p_peek_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && load && !retx) |=> $stable(rd_ptr));

    p_rewind_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        retx |=> (rd_ptr == '0));
endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(AW+1), .DW(DW)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .load         (load),
    .retx         (retx),
    .sync_mode    (sync_mode),
    .full         (full),
    .empty        (empty),
    .half_full    (half_full),
    .almost_full  (almost_full),
    .almost_empty (almost_empty),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .rd_word      (rd_word)
);

// File: tb/tb_pflag_fifo.sv
module tb_pflag_fifo;
    localparam int DEPTH = 64;
    localparam int DW    = 18;
    localparam int MASK  = DEPTH - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, load = 1'b0, retx = 1'b0;
    logic          out_en = 1'b1, sync_mode = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty, almost_empty, half_full, almost_full, full;

    always #10 clk = ~clk;

    pflag_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .load(load),
        .rd_en(rd_en), .retx(retx), .out_en(out_en), .sync_mode(sync_mode),
        .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
        .half_full(half_full), .almost_full(almost_full), .full(full)
    );

    // Behavioural reference: word counts, pointer history, written words by index.
    int            n_cmp = 0, n_bad = 0;
    string         phase = "R10";
    bit            done = 0;
    int            W, R, Ws1, Ws2, Rs1, Rs2, lo, hi, selw, selr;
    logic [DW-1:0] q;
    bit            afr, aer;
    logic [DW-1:0] hist [int];

    function automatic bit m_full();  return (W - Rs2) == DEPTH;      endfunction
    function automatic bit m_half();  return (W - Rs2) > DEPTH / 2;   endfunction
    function automatic bit m_afc();   return (W - Rs2) >= DEPTH - hi; endfunction
    function automatic bit m_empty(); return (Ws2 - R) == 0;          endfunction
    function automatic bit m_aec();   return (Ws2 - R) <= lo;         endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            W = 0; R = 0; Ws1 = 0; Ws2 = 0; Rs1 = 0; Rs2 = 0;
            lo = 7; hi = 7; selw = 0; selr = 0; q = '0; afr = 0; aer = 1;
            hist.delete();
        end else begin
            bit f_pre, e_pre;
            int wp, rp;
            f_pre = m_full(); e_pre = m_empty();
            afr = m_afc(); aer = m_aec();
            wp = W; rp = R;
            if (rd_en && load) begin
                q = DW'(selr ? hi : lo);
                selr ^= 1;
            end
            if (wr_en && load) begin
                if (selw == 0) lo = int'(wr_data) & MASK;
                else           hi = int'(wr_data) & MASK;
                selw ^= 1;
            end
            if (wr_en && !load && !f_pre) begin
                hist[W] = wr_data;
                W++;
            end
            if (retx) R = 0;
            else if (rd_en && !load && !e_pre) begin
                q = hist[R];
                R++;
            end
            Rs2 = Rs1; Rs1 = rp;
            Ws2 = Ws1; Ws1 = wp;
        end
    end

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at %0t: actual %0h expected %0h", what, phase, $time, got, exp);
        end
    endtask

    // Compare every cycle, 5 ns after the rising edge.
    always @(posedge clk) begin
        #5;
        chk("R1/R11 rd_data", 32'(rd_data), 32'(out_en ? q : '0));
        chk("R2 full", 32'(full), 32'(m_full()));
        chk("R3 empty", 32'(empty), 32'(m_empty()));
        chk("R4 half_full", 32'(half_full), 32'(m_half()));
        chk("R5/R6 almost_full", 32'(almost_full), 32'(sync_mode ? afr : m_afc()));
        chk("R5/R6 almost_empty", 32'(almost_empty), 32'(sync_mode ? aer : m_aec()));
    end

    task automatic drive(input logic w, input logic [DW-1:0] d, input logic r,
                         input logic l, input logic t);
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; load = l; retx = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 0);
    endtask

    task automatic fill_drain();
        for (int i = 0; i < DEPTH; i++) drive(1, DW'(i * 7 + 3), 0, 0, 0);
        idle(3);
        for (int i = 0; i < DEPTH + 2; i++) drive(0, '0, 1, 0, 0);
        idle(3);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        phase = "R10";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        phase = "R1";
        for (int i = 0; i < 10; i++) drive(1, DW'(100 + i), 0, 0, 0);
        idle(3);
        for (int i = 0; i < 12; i++) drive(0, '0, 1, 0, 0);   // last reads hit empty (R3)
        idle(3);

        phase = "R11";
        for (int i = 0; i < 4; i++) drive(1, DW'(200 + i), 0, 0, 0);
        idle(3);
        out_en = 1'b0;
        drive(0, '0, 1, 0, 0); drive(0, '0, 1, 0, 0);
        idle(1);
        out_en = 1'b1;
        drive(0, '0, 1, 0, 0); drive(0, '0, 1, 0, 0);
        idle(3);

        phase = "R2";
        for (int i = 0; i < DEPTH + 6; i++) drive(1, DW'(i * 3 + 1), 0, 0, 0);
        idle(3);

        phase = "R3";
        for (int i = 0; i < DEPTH + 6; i++) drive(0, '0, 1, 0, 0);
        idle(3);

        phase = "R4";
        for (int i = 0; i < 150; i++) drive(i % 3 != 0, DW'(i + 500), i % 2 == 0, 0, 0);
        for (int i = 0; i < DEPTH + 4; i++) drive(0, '0, 1, 0, 0);
        idle(3);

        phase = "R7";
        drive(1, DW'(20), 0, 1, 0);
        drive(1, DW'(18'h100 | 40), 0, 1, 0);   // upper bits masked off
        idle(3);

        phase = "R8";
        drive(0, '0, 1, 1, 0);
        drive(0, '0, 1, 1, 0);
        idle(3);

        phase = "R5";
        fill_drain();

        phase = "R6";
        sync_mode = 1'b1;
        fill_drain();
        sync_mode = 1'b0;
        idle(2);

        phase = "R10";
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        drive(0, '0, 1, 1, 0);   // default low mark
        drive(0, '0, 1, 1, 0);   // default high mark
        idle(3);

        phase = "R9";
        for (int i = 0; i < 20; i++) drive(1, DW'(900 + i), 0, 0, 0);
        idle(3);
        for (int i = 0; i < 8; i++) drive(0, '0, 1, 0, 0);
        drive(0, '0, 1, 0, 1);   // rewind wins over the read strobe
        idle(2);
        for (int i = 0; i < 25; i++) drive(0, '0, 1, 0, 0);
        idle(3);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (phase %s): actual running expected finished", phase);
            summary();
            $finish;
        end
    end
endmodule